// File: doc/BRIEF.md
# Supervised Glitch-Free System Clock Selector

This block selects the system clock from two sources: an internal RC oscillator that is always present and an external clock that may be absent or may stop. After reset the internal source drives the system clock. Software may then ask for the external source by holding a request level high. The handover uses a break-before-make handshake, so the output clock never carries a runt pulse during a normal switch.

While the external source drives the system clock, a supervisor clocked by the internal oscillator checks that external edges keep arriving. An external-domain flop toggles on each external rising edge. The supervisor synchronises that toggle and counts internal cycles since the last change it saw. When the count passes the `TIMEOUT` parameter, the block declares a failure. It then clears the external gate at once, without waiting for an external edge, and hands the system clock back to the internal source. It also sets a sticky failure flag and raises an interrupt if software has enabled one. The flag stays set until software clears it. While the flag is set, a standing request for the external source is not honoured.

Top module: `clkguard_top`

## Requirements
- R1: While reset is held and after it is released, `src_is_ext` is 0, `clk_fail` is 0, `fail_irq` is 0, and `sys_clk` toggles at the internal oscillator rate.
- R2: Once `sw_sel_ext` is 1 and `clk_fail` is 0, `src_is_ext` becomes 1 within a few cycles of each clock, and `sys_clk` then toggles at the external rate.
- R3: When `sw_sel_ext` returns to 0, `src_is_ext` returns to 0 and `sys_clk` again toggles at the internal rate.
- R4: The internal gate and the external gate are never open at the same time. The old clock is gated off on its falling edge before the new clock is enabled.
- R5: No failure is declared while external edges keep arriving. No failure is declared earlier than `TIMEOUT` internal cycles after the last external edge, and the supervisor count never passes `TIMEOUT`+1.
- R6: While the external source is in use, if no external edge arrives for more than `TIMEOUT` internal cycles, `clk_fail` becomes 1 and `src_is_ext` returns to 0. `sys_clk` resumes at the internal rate even when the external clock has stopped completely.
- R7: The supervisor is armed only while the external source drives `sys_clk`. An external clock that stops while the internal source is selected sets no flag.
- R8: `clk_fail` stays 1 until a one-cycle pulse on `flag_clr`. After that it reads 0, and the external source can be selected again.
- R9: While `clk_fail` is 1, `sw_sel_ext`=1 has no effect: `src_is_ext` stays 0 and `sys_clk` stays on the internal source.
- R10: `fail_irq` is 1 exactly when `clk_fail` was 1 and `irq_en` was 1 one internal cycle earlier. With `irq_en`=0 a failure still sets `clk_fail` but leaves `fail_irq` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int | input | 1 | Internal oscillator clock; also clocks the supervisor and the status logic |
| clk_ext | input | 1 | External clock; may stop at any time |
| rst_n | input | 1 | Active-low reset, released synchronously to `clk_int` |
| sw_sel_ext | input | 1 | Software request level: 1 asks for the external source |
| irq_en | input | 1 | Enables the failure interrupt |
| flag_clr | input | 1 | One-cycle pulse that clears the failure flag |
| sys_clk | output | 1 | Gated, glitch-free system clock |
| src_is_ext | output | 1 | 1 while the external source drives `sys_clk` (synchronised to `clk_int`) |
| clk_fail | output | 1 | Sticky external-clock failure flag |
| fail_irq | output | 1 | Failure interrupt, registered |

## Verification
The assertions assume that `sw_sel_ext`, `irq_en` and `flag_clr` are synchronous to `clk_int`. They also assume that the external clock, while running, is slow enough relative to the internal clock for each toggle of its edge marker to be seen. The bench drives all control inputs one nanosecond after an internal rising edge. Its external clock runs at a 22 ns period against the 8 ns internal period, so a running source always refreshes the supervisor long before the timeout. The bench stops the external clock only by holding it low. It never clears the flag during the two cycles in which the status is still falling after a failure.

// File: rtl/clkguard_pkg.sv
package clkguard_pkg;

  // Failure is declared once the idle count has passed the limit.
  function automatic logic past_limit(input int unsigned cnt, input int unsigned lim);
    return cnt > lim;
  endfunction

  // Internal leg may open only when not selecting external and external gate is shut.
  function automatic logic int_may_open(input logic want_ext, input logic ext_open);
    return !want_ext && !ext_open;
  endfunction

  // External leg may open only when selecting external and internal gate is shut.
  function automatic logic ext_may_open(input logic want_ext, input logic int_open);
    return want_ext && !int_open;
  endfunction

  function automatic int unsigned cnt_width(input int unsigned lim);
    return $clog2(lim + 2);
  endfunction

endpackage

// File: rtl/cg_sync.sv
module cg_sync #(
  parameter int  STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain <= RST_VAL;
        else         chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain <= {STAGES{RST_VAL}};
        else         chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cg_gate_leg.sv
module cg_gate_leg #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic want,
  output logic gate_on
);
  logic want_s;

  cg_sync #(.STAGES(STAGES), .RST_VAL(RST_VAL)) u_sync (
    .clk    (clk),
    .arst_n (arst_n),
    .d      (want),
    .q      (want_s)
  );

  // Gate changes only while this clock is low, so no partial pulse leaves.
  always_ff @(negedge clk or negedge arst_n) begin
    if (!arst_n) gate_on <= RST_VAL;
    else         gate_on <= want_s;
  end
endmodule

// File: rtl/cg_edge_monitor.sv
module cg_edge_monitor
  import clkguard_pkg::*;
#(
  parameter int TIMEOUT = 16,
  parameter int STAGES  = 2,
  localparam int CW     = cnt_width(TIMEOUT)
) (
  input  logic          clk_int,
  input  logic          clk_ext,
  input  logic          rst_n,
  input  logic          armed,
  output logic          edge_seen,
  output logic          fail_evt,
  output logic [CW-1:0] idle_cnt
);
  logic ext_tgl;
  logic tgl_s;
  logic tgl_prev;
  logic hit;

  // Marker toggles on every external rising edge.
  always_ff @(posedge clk_ext or negedge rst_n) begin
    if (!rst_n) ext_tgl <= 1'b0;
    else        ext_tgl <= !ext_tgl;
  end

  cg_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_tsync (
    .clk    (clk_int),
    .arst_n (rst_n),
    .d      (ext_tgl),
    .q      (tgl_s)
  );

  always_ff @(posedge clk_int or negedge rst_n) begin
    if (!rst_n) tgl_prev <= 1'b0;
    else        tgl_prev <= tgl_s;
  end

  assign edge_seen = tgl_s ^ tgl_prev;
  assign hit       = past_limit(32'(idle_cnt), TIMEOUT);
  assign fail_evt  = armed && hit;

  always_ff @(posedge clk_int or negedge rst_n) begin
    if (!rst_n)                 idle_cnt <= '0;
    else if (!armed || edge_seen) idle_cnt <= '0;
    else if (!hit)              idle_cnt <= idle_cnt + 1'b1;
  end
endmodule

// File: rtl/cg_fail_ctrl.sv
module cg_fail_ctrl (
  input  logic clk_int,
  input  logic rst_n,
  input  logic sw_sel_ext,
  input  logic irq_en,
  input  logic flag_clr,
  input  logic fail_evt,
  output logic sel_eff,
  output logic flag,
  output logic irq_q
);
  always_ff @(posedge clk_int or negedge rst_n) begin
    if (!rst_n) begin
      flag    <= 1'b0;
      sel_eff <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      // A new failure wins over a clear in the same cycle.
      if (fail_evt)      flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
      sel_eff <= sw_sel_ext && !flag && !fail_evt;
      irq_q   <= flag && irq_en;
    end
  end
endmodule

// File: rtl/clkguard_top.sv
module clkguard_top
  import clkguard_pkg::*;
#(
  parameter int TIMEOUT     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_int,
  input  logic clk_ext,
  input  logic rst_n,
  input  logic sw_sel_ext,
  input  logic irq_en,
  input  logic flag_clr,
  output logic sys_clk,
  output logic src_is_ext,
  output logic clk_fail,
  output logic fail_irq
);
  localparam int CW = cnt_width(TIMEOUT);

  logic          sel_eff;
  logic          int_gate;
  logic          ext_gate;
  logic          ext_arst_n;
  logic          src_ext;
  logic          edge_seen;
  logic          fail_evt;
  logic [CW-1:0] mon_cnt;

  // Forced release: the flag clears the external leg without an external edge.
  assign ext_arst_n = rst_n && !clk_fail;

  cg_gate_leg #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_int_leg (
    .clk     (clk_int),
    .arst_n  (rst_n),
    .want    (int_may_open(sel_eff, ext_gate)),
    .gate_on (int_gate)
  );

  cg_gate_leg #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ext_leg (
    .clk     (clk_ext),
    .arst_n  (ext_arst_n),
    .want    (ext_may_open(sel_eff, int_gate)),
    .gate_on (ext_gate)
  );

  cg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_src_sync (
    .clk    (clk_int),
    .arst_n (rst_n),
    .d      (ext_gate),
    .q      (src_ext)
  );

  cg_edge_monitor #(.TIMEOUT(TIMEOUT), .STAGES(SYNC_STAGES)) u_mon (
    .clk_int   (clk_int),
    .clk_ext   (clk_ext),
    .rst_n     (rst_n),
    .armed     (src_ext),
    .edge_seen (edge_seen),
    .fail_evt  (fail_evt),
    .idle_cnt  (mon_cnt)
  );

  cg_fail_ctrl u_ctrl (
    .clk_int    (clk_int),
    .rst_n      (rst_n),
    .sw_sel_ext (sw_sel_ext),
    .irq_en     (irq_en),
    .flag_clr   (flag_clr),
    .fail_evt   (fail_evt),
    .sel_eff    (sel_eff),
    .flag       (clk_fail),
    .irq_q      (fail_irq)
  );

  assign sys_clk    = (clk_int && int_gate) || (clk_ext && ext_gate);
  assign src_is_ext = src_ext;
endmodule

// File: rtl/clkguard_checker.sv
module clkguard_checker #(
  parameter int TIMEOUT = 16,
  parameter int CW      = 5
) (
  input logic          clk_int,
  input logic          rst_n,
  input logic          irq_en,
  input logic          flag_clr,
  input logic          int_gate,
  input logic          ext_gate,
  input logic          src_ext,
  input logic          clk_fail,
  input logic          fail_irq,
  input logic          fail_evt,
  input logic [CW-1:0] mon_cnt
);
  a_r1_reset_state: assert property (@(posedge clk_int) disable iff (!rst_n)
    $rose(rst_n) |-> (!src_ext && !clk_fail && !fail_irq));

  a_r4_exclusive_gates: assert property (@(posedge clk_int) disable iff (!rst_n)
    !(int_gate && ext_gate));

  a_r5_cnt_bound: assert property (@(posedge clk_int) disable iff (!rst_n)
    32'(mon_cnt) <= TIMEOUT + 1);

  a_r6_fail_only_armed: assert property (@(posedge clk_int) disable iff (!rst_n)
    $rose(clk_fail) |-> $past(src_ext));

  a_r8_flag_sticky: assert property (@(posedge clk_int) disable iff (!rst_n)
    (clk_fail && !flag_clr) |=> clk_fail);

  a_r8_flag_clears: assert property (@(posedge clk_int) disable iff (!rst_n)
    (flag_clr && !fail_evt) |=> !clk_fail);

  a_r9_no_reselect: assert property (@(posedge clk_int) disable iff (!rst_n)
    $rose(src_ext) |-> !$past(clk_fail));

  a_r10_irq_gated: assert property (@(posedge clk_int) disable iff (!rst_n)
    fail_irq |-> ($past(irq_en) && $past(clk_fail)));
endmodule

bind clkguard_top clkguard_checker #(.TIMEOUT(TIMEOUT), .CW(CW)) u_chk (
  .clk_int  (clk_int),
  .rst_n    (rst_n),
  .irq_en   (irq_en),
  .flag_clr (flag_clr),
  .int_gate (int_gate),
  .ext_gate (ext_gate),
  .src_ext  (src_ext),
  .clk_fail (clk_fail),
  .fail_irq (fail_irq),
  .fail_evt (fail_evt),
  .mon_cnt  (mon_cnt)
);

// File: tb/sim_clkguard_top.sv
module sim_clkguard_top;
  logic clk_int = 1'b0;
  logic clk_ext = 1'b0;
  logic rst_n = 1'b0;
  logic sw_sel_ext = 1'b0;
  logic irq_en = 1'b0;
  logic flag_clr = 1'b0;
  logic ext_run = 1'b1;
  logic sys_clk, src_is_ext, clk_fail, fail_irq;

  int checks = 0;
  int fails = 0;
  int sys_edges = 0;
  bit done = 0;

  typedef struct {
    string req;
    logic  src;
    logic  flg;
    logic  irq;
  } exp_t;
  exp_t sb[$];

  clkguard_top u0 (
    .clk_int(clk_int), .clk_ext(clk_ext), .rst_n(rst_n),
    .sw_sel_ext(sw_sel_ext), .irq_en(irq_en), .flag_clr(flag_clr),
    .sys_clk(sys_clk), .src_is_ext(src_is_ext), .clk_fail(clk_fail),
    .fail_irq(fail_irq)
  );

  always #4 clk_int = !clk_int;

  initial begin
    forever begin
      if (ext_run) begin
        clk_ext = 1'b1; #11;
        clk_ext = 1'b0; #11;
      end else begin
        clk_ext = 1'b0; #1;
      end
    end
  end

  always @(posedge sys_clk) sys_edges++;

  // Driver side: queue one expected status item.
  task automatic expect_st(input string req, input logic s, input logic f, input logic i);
    exp_t e;
    e.req = req; e.src = s; e.flg = f; e.irq = i;
    sb.push_back(e);
  endtask

  // Monitor side: compare queued items at the falling edge.
  initial begin
    forever begin
      @(negedge clk_int);
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (src_is_ext !== e.src || clk_fail !== e.flg || fail_irq !== e.irq) begin
          fails++;
          $display("FAIL %s: src/flag/irq = %b%b%b, expected %b%b%b",
                   e.req, src_is_ext, clk_fail, fail_irq, e.src, e.flg, e.irq);
        end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk_int);
    #1;
  endtask

  task automatic rate_check(input string req, input int n, input int lo, input int hi);
    int s;
    s = sys_edges;
    repeat (n) @(posedge clk_int);
    #1;
    checks++;
    if ((sys_edges - s) < lo || (sys_edges - s) > hi) begin
      fails++;
      $display("FAIL %s: sys_clk edges = %0d, expected %0d..%0d", req, sys_edges - s, lo, hi);
    end
  endtask

  initial begin
    cyc(5);
    expect_st("R1 during reset", 0, 0, 0);
    cyc(1);
    rst_n = 1'b1;
    cyc(3);
    expect_st("R1 after reset", 0, 0, 0);
    rate_check("R1 internal rate", 20, 19, 21);

    irq_en = 1'b1;
    sw_sel_ext = 1'b1;
    cyc(30);
    expect_st("R2 external selected", 1, 0, 0);
    rate_check("R2 external rate", 40, 13, 16);

    sw_sel_ext = 1'b0;
    cyc(30);
    expect_st("R3 back to internal", 0, 0, 0);
    rate_check("R3 internal rate", 20, 19, 21);

    ext_run = 1'b0;
    cyc(60);
    expect_st("R7 unarmed stop", 0, 0, 0);
    ext_run = 1'b1;
    cyc(5);

    sw_sel_ext = 1'b1;
    cyc(30);
    expect_st("R2 reselect", 1, 0, 0);
    cyc(100);
    expect_st("R5 running source no fail", 1, 0, 0);

    ext_run = 1'b0;
    cyc(8);
    expect_st("R5 before timeout", 1, 0, 0);
    cyc(40);
    expect_st("R6 R10 failure", 0, 1, 1);
    rate_check("R6 internal after stop", 20, 19, 21);

    ext_run = 1'b1;
    cyc(40);
    expect_st("R9 R8 request ignored", 0, 1, 1);
    rate_check("R9 stays internal", 20, 19, 21);

    irq_en = 1'b0;
    cyc(3);
    expect_st("R10 irq disabled", 0, 1, 0);

    sw_sel_ext = 1'b0;
    flag_clr = 1'b1;
    cyc(1);
    flag_clr = 1'b0;
    cyc(3);
    expect_st("R8 cleared", 0, 0, 0);

    sw_sel_ext = 1'b1;
    cyc(30);
    expect_st("R8 reselect after clear", 1, 0, 0);
    ext_run = 1'b0;
    cyc(50);
    expect_st("R10 fail without irq", 0, 1, 0);

    cyc(2);
    done = 1;
  end

  initial begin
    int n = 0;
    while (!done && n < 20000) begin
      @(posedge clk_int);
      n++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule